// File: doc/BRIEF.md
# Backup Supply Switchover and Chip-Enable Gating Controller

This block is the digital control core of a power supervisor. Two analog comparators give it their flags. One flag says that the main supply is above the reset threshold. The other says that the main supply is above the backup (battery) voltage. From these flags the block decides which source feeds the protected output rail, reports when the battery is in use, and drives an active-low undervoltage line. Both flags come from the analog domain, so each passes through a two-flop synchroniser before any logic uses it.

The block also gates the active-low chip-enable of an external memory. Normally a request reaches the memory only while the main supply is healthy and the supervisor is not holding the system in reset. If the request is already active at the moment reset-active rises, the block keeps the gated enable active for a fixed window of about 15 µs. This lets a write cycle already in progress finish. The window ends early if the request is released. Once the window closes, the enable stays blocked until reset-active falls. The window length is counted in clock cycles, derived from a clock-frequency parameter.

Top module: `supply_switchover_gate`

## Requirements
- R1: When both synchronised flags (above threshold, above backup) are 1, `sel_main_o` becomes 1 (1 = main supply, 0 = backup). The change appears on the third rising clock edge after the flags change.
- R2: When both synchronised flags are 0, `sel_main_o` becomes 0 with the same three-edge latency.
- R3: When the two synchronised flags differ, `sel_main_o` keeps its previous value. After the synchronous reset `rst` (active high), `sel_main_o` is 1.
- R4: `batt_on_o` is always the inverse of `sel_main_o`.
- R5: `undervolt_n_o` equals the synchronised above-threshold flag. It follows `main_above_thr_i` in both directions after exactly two rising edges, with no further delay.
- R6: While `rst_active_i` is 0 and no hold window is open, `ce_n_o` is 0 exactly when `ce_req_n_i` is 0 and the synchronised above-threshold flag is 1; otherwise it is 1.
- R7: If `ce_req_n_i` is 0 in the first cycle in which `rst_active_i` is 1 (a rising edge), `ce_n_o` stays 0 for HOLD cycles, with HOLD = (CLK_HZ/1e6)*HOLD_US (1500 at the defaults). This includes that first cycle and holds regardless of the threshold flag. `ce_n_o` returns to 1 in the following cycle.
- R8: Raising `ce_req_n_i` during the hold window drives `ce_n_o` to 1 in the same cycle and ends the window for good. A later low request does not reopen it.
- R9: While `rst_active_i` is 1 and no hold window is open, `ce_n_o` is 1 whatever the request. This also covers a rising edge of `rst_active_i` that arrives with the request already high.
- R10: Gating resumes per R6 as soon as `rst_active_i` returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| main_above_thr_i | input | 1 | Comparator flag: main supply above reset threshold (asynchronous) |
| main_above_batt_i | input | 1 | Comparator flag: main supply above backup voltage (asynchronous) |
| rst_active_i | input | 1 | Supervisor reset-active indication, synchronous, active high |
| ce_req_n_i | input | 1 | Chip-enable request, active low |
| sel_main_o | output | 1 | Supply select: 1 main, 0 backup |
| batt_on_o | output | 1 | High while the backup supply is selected |
| undervolt_n_o | output | 1 | Active-low undervoltage indicator |
| ce_n_o | output | 1 | Gated chip-enable to memory, active low |

## Verification
The assertions check several rules on every cycle:
- the select decision for the two agreeing flag pairs and the hold for the mixed pairs;
- the inverse relation between the select and battery indicator;
- that an inactive request never enables the memory;
- that reset-active with no open window always blocks the enable;
- that a request held across a rising edge of reset-active is passed through.

Only the bench's scenarios can show the latencies through the synchroniser, the exact length of the 1500-cycle window and its end, early cancellation that does not reopen, and the resumption of normal gating after reset-active falls.

// File: rtl/ssg_pkg.sv
package ssg_pkg;

  // Cycles in the hold window: whole cycles per microsecond times microseconds, at least one.
  function automatic int hold_cycles(input int clk_hz, input int hold_us);
    int c;
    c = (clk_hz / 1_000_000) * hold_us;
    return (c < 1) ? 1 : c;
  endfunction

  // Supply decision: agreeing flags decide, disagreeing flags keep the current choice.
  function automatic logic next_sel_main(input logic cur, input logic above_thr,
                                         input logic above_batt);
    if (above_thr && above_batt)        return 1'b1;
    else if (!above_thr && !above_batt) return 1'b0;
    else                                return cur;
  endfunction

endpackage

// File: rtl/ssg_sync2.sv
module ssg_sync2 #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta, stab;
    always_ff @(posedge clk) begin
      if (rst) begin
        meta <= 1'b0;
        stab <= 1'b0;
      end else begin
        meta <= d[i];
        stab <= meta;
      end
    end
    assign q[i] = stab;
  end
endmodule

// File: rtl/ssg_supply_sel.sv
module ssg_supply_sel
  import ssg_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic above_thr,
  input  logic above_batt,
  output logic sel_main
);
  always_ff @(posedge clk) begin
    if (rst) sel_main <= 1'b1;
    else     sel_main <= next_sel_main(sel_main, above_thr, above_batt);
  end
endmodule

// File: rtl/ssg_ce_gate.sv
module ssg_ce_gate
  import ssg_pkg::*;
#(
  parameter int CLK_HZ  = 100_000_000,
  parameter int HOLD_US = 15
) (
  input  logic clk,
  input  logic rst,
  input  logic req_n,
  input  logic thr_ok,
  input  logic rst_act,
  output logic ce_n,
  output logic hold_active,
  output logic rst_rise
);
  localparam int HOLD = hold_cycles(CLK_HZ, HOLD_US);
  localparam int CW   = $clog2(HOLD + 1);

  logic          rst_act_q;
  logic [CW-1:0] hold_cnt;
  logic          req_on;

  assign req_on   = ~req_n;
  assign rst_rise = rst_act & ~rst_act_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rst_act_q <= 1'b0;
      hold_cnt  <= '0;
    end else begin
      rst_act_q <= rst_act;
      if (!req_on)
        hold_cnt <= '0;
      else if (rst_rise)
        hold_cnt <= CW'(HOLD - 1);
      else if (hold_cnt != '0)
        hold_cnt <= hold_cnt - 1'b1;
    end
  end

  assign hold_active = req_on & (rst_rise | (hold_cnt != '0));
  assign ce_n        = ~(hold_active | (req_on & thr_ok & ~rst_act));
endmodule

// File: rtl/supply_switchover_gate.sv
module supply_switchover_gate #(
  parameter int CLK_HZ  = 100_000_000,
  parameter int HOLD_US = 15
) (
  input  logic clk,
  input  logic rst,
  input  logic main_above_thr_i,
  input  logic main_above_batt_i,
  input  logic rst_active_i,
  input  logic ce_req_n_i,
  output logic sel_main_o,
  output logic batt_on_o,
  output logic undervolt_n_o,
  output logic ce_n_o
);
  logic [1:0] flags_s;
  logic       thr_s, batt_s;
  logic       sel_main;
  logic       hold_active, rst_rise;

  ssg_sync2 #(.W(2)) u_sync (
    .clk(clk), .rst(rst),
    .d({main_above_batt_i, main_above_thr_i}),
    .q(flags_s)
  );
  assign thr_s  = flags_s[0];
  assign batt_s = flags_s[1];

  ssg_supply_sel u_sel (
    .clk(clk), .rst(rst),
    .above_thr(thr_s), .above_batt(batt_s),
    .sel_main(sel_main)
  );

  ssg_ce_gate #(.CLK_HZ(CLK_HZ), .HOLD_US(HOLD_US)) u_gate (
    .clk(clk), .rst(rst),
    .req_n(ce_req_n_i), .thr_ok(thr_s), .rst_act(rst_active_i),
    .ce_n(ce_n_o), .hold_active(hold_active), .rst_rise(rst_rise)
  );

  assign sel_main_o    = sel_main;
  assign batt_on_o     = ~sel_main;
  assign undervolt_n_o = thr_s;
endmodule

// File: rtl/supply_switchover_chk.sv
module supply_switchover_chk (
  input logic clk,
  input logic rst,
  input logic thr_s,
  input logic batt_s,
  input logic sel_main_o,
  input logic batt_on_o,
  input logic ce_req_n_i,
  input logic rst_active_i,
  input logic ce_n_o,
  input logic hold_active,
  input logic rst_rise
);
  a_r1_main_on_both_high: assert property (@(posedge clk) disable iff (rst)
    (thr_s && batt_s) |=> sel_main_o);

  a_r2_backup_on_both_low: assert property (@(posedge clk) disable iff (rst)
    (!thr_s && !batt_s) |=> !sel_main_o);

  a_r3_hold_on_mixed: assert property (@(posedge clk) disable iff (rst)
    (thr_s != batt_s) |=> $stable(sel_main_o));

  a_r4_batt_inverse: assert property (@(posedge clk) disable iff (rst)
    batt_on_o != sel_main_o);

  a_r6_idle_req_blocks: assert property (@(posedge clk) disable iff (rst)
    ce_req_n_i |-> ce_n_o);

  a_r7_rise_passes_req: assert property (@(posedge clk) disable iff (rst)
    (rst_rise && !ce_req_n_i) |-> !ce_n_o);

  a_r9_reset_blocks: assert property (@(posedge clk) disable iff (rst)
    (rst_active_i && !hold_active) |-> ce_n_o);
endmodule

bind supply_switchover_gate supply_switchover_chk u_chk (
  .clk(clk), .rst(rst), .thr_s(thr_s), .batt_s(batt_s),
  .sel_main_o(sel_main_o), .batt_on_o(batt_on_o),
  .ce_req_n_i(ce_req_n_i), .rst_active_i(rst_active_i),
  .ce_n_o(ce_n_o), .hold_active(hold_active), .rst_rise(rst_rise)
);

// File: tb/tb_supply_switchover_gate.sv
`timescale 1ns/1ps
module tb_supply_switchover_gate;
  localparam int HOLD = 100 * 15;  // 100 cycles per microsecond at 100 MHz, 15 us

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic thr = 1'b0, batt = 1'b0, ract = 1'b0, req_n = 1'b1;
  logic sel_main, batt_on, uv_n, ce_n;
  int checks = 0, errors = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  supply_switchover_gate dut (
    .clk(clk), .rst(rst),
    .main_above_thr_i(thr), .main_above_batt_i(batt),
    .rst_active_i(ract), .ce_req_n_i(req_n),
    .sel_main_o(sel_main), .batt_on_o(batt_on),
    .undervolt_n_o(uv_n), .ce_n_o(ce_n)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic model_sel(input logic cur, input logic t, input logic b);
    return (t == b) ? t : cur;
  endfunction

  initial begin
    #5_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic exp_sel;
    cyc(4);
    chk("R3 reset select", sel_main, 1'b1);
    chk("R4 reset batt_on", batt_on, 1'b0);
    chk("R6 reset ce", ce_n, 1'b1);
    rst = 1'b0;
    cyc(2);

    // Supply select sweep: every starting state against every flag pair
    for (int s = 0; s < 2; s++) begin
      for (int c = 0; c < 4; c++) begin
        thr = s[0]; batt = s[0];
        cyc(3);
        chk("R1/R2 preset", sel_main, s[0]);
        exp_sel = s[0];
        thr = c[0]; batt = c[1];
        cyc(2);
        chk("R3 no change before third edge", sel_main, exp_sel);
        chk("R5 undervolt after two edges", uv_n, c[0]);
        cyc(1);
        exp_sel = model_sel(exp_sel, c[0], c[1]);
        if (c[0] == c[1]) chk(c[0] ? "R1 main select" : "R2 backup select", sel_main, exp_sel);
        else              chk("R3 mixed hold", sel_main, exp_sel);
        chk("R4 batt_on inverse", batt_on, ~exp_sel);
      end
    end

    // R5: one-edge check of undervolt latency both ways
    thr = 1'b1; cyc(3);
    thr = 1'b0; cyc(1);
    chk("R5 not yet low after one edge", uv_n, 1'b1);
    cyc(1);
    chk("R5 low after two edges", uv_n, 1'b0);
    thr = 1'b1; cyc(2);
    chk("R5 high after two edges", uv_n, 1'b1);

    // R6: gating sweep with reset-active low
    for (int t = 0; t < 2; t++) begin
      for (int r = 0; r < 2; r++) begin
        thr = t[0]; cyc(3);
        req_n = r[0]; #1;
        chk("R6 normal gating", ce_n, ~(t[0] & ~r[0]));
        cyc(1);
      end
    end

    // R7: full hold window while supply falls
    thr = 1'b1; req_n = 1'b0; cyc(3);
    chk("R6 enabled before reset", ce_n, 1'b0);
    ract = 1'b1; thr = 1'b0; #1;
    chk("R7 first hold cycle", ce_n, 1'b0);
    for (int k = 1; k <= HOLD; k++) begin
      cyc(1);
      if (k == HOLD - 1) chk("R7 last hold cycle", ce_n, 1'b0);
      else if (k == HOLD) chk("R7 window closed", ce_n, 1'b1);
      else if (ce_n !== 1'b0) chk("R7 inside window", ce_n, 1'b0);
    end
    cyc(20);
    chk("R9 stays blocked after window", ce_n, 1'b1);
    thr = 1'b1; cyc(3);
    chk("R9 blocked with supply back", ce_n, 1'b1);
    ract = 1'b0; #1;
    chk("R10 resumes on reset release", ce_n, 1'b0);
    cyc(2);

    // R8: cancel the window early
    ract = 1'b1; #1;
    chk("R7 hold starts", ce_n, 1'b0);
    cyc(5);
    chk("R7 hold running", ce_n, 1'b0);
    req_n = 1'b1; #1;
    chk("R8 release ends window", ce_n, 1'b1);
    cyc(1);
    req_n = 1'b0; #1;
    chk("R8 window not reopened", ce_n, 1'b1);
    cyc(10);
    chk("R8 still closed", ce_n, 1'b1);
    ract = 1'b0; #1;
    chk("R10 resumes", ce_n, 1'b0);
    cyc(2);

    // R9: rising edge with request already high
    req_n = 1'b1; cyc(1);
    ract = 1'b1; cyc(1);
    req_n = 1'b0; #1;
    chk("R9 no window without request", ce_n, 1'b1);
    cyc(3);
    chk("R9 blocked", ce_n, 1'b1);
    ract = 1'b0; #1;
    chk("R10 resumes after late request", ce_n, 1'b0);
    cyc(2);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule